// File: doc/BRIEF.md
# Debug Control Register with Reset Sequencing

This block is the control register a debugger reaches through a debug access port. It holds eight control bits and turns them into requests for the rest of the chip: a flash mass-erase request, a core halt request, and the system and core reset outputs. It also runs a deep-sleep recovery handshake. When the debugger asks for it before the chip enters a deep low-power mode, the system is held in reset on wake until the debugger acknowledges that it has set up its debug logic again.

The bits do not all live the same way. The erase trigger clears when the erase finishes. The lockout bit freezes the register until a debug reset. The sleep request and acknowledge bits clear when the chip recovers from deep sleep. The core-park bit keeps the core in reset after a system reset ends, for as long as the bit stays set. A sticky flag reports each deep-sleep entry, and the debugger clears it through an acknowledge bit.

Top module: `dbg_ctl_reg`

## Requirements
- R1: Writing 1 to bit 0 sets it, and writing 0 to it has no effect. `erase_req` equals bit 0 AND `erase_allow`. While `erase_allow` is high, an `erase_done` pulse clears bit 0 at the next edge.
- R2: While `erase_allow` is low, `erase_req` stays low and `erase_done` is ignored. Bit 0 stays set until `sys_rst_out` is high at a clock edge, which clears it.
- R3: Writing 1 to bit 1 sets the lockout. While it is set, every write is ignored. It stays set until `dbg_rst` or `por`.
- R4: `halt_req` follows bit 2 from the cycle after that bit is written.
- R5: `sys_rst_out` is high in every cycle in which bit 3 is set.
- R6: Suppose bit 4 is set when system reset ends. Then `core_rst_out` stays high after `sys_rst_out` falls, and it falls in the cycle right after a write that clears bit 4. If bit 4 is 0, `core_rst_out` falls together with `sys_rst_out`.
- R7: Bit 5 is sampled on a `sleep_enter` pulse. If the sampled value was 1, `sys_rst_out` goes high from the cycle after `sleep_exit`. It stays high until the cycle after an accepted write with bit 6 set. If the sampled value was 0, exit causes no hold.
- R8: `sleep_exit` clears bits 5 and 6. Bit 6 can also be written back to 0.
- R9: `sleep_status` goes high the cycle after `sleep_enter`. An accepted write with bit 7 set clears it. Bit 7 holds the last value written.
- R10: `por` clears all bits and internal state, leaving every output low. `dbg_rst` clears bits 1 to 4 and leaves the other bits unchanged.
- R11: `rd_data` returns the register bits at their bit positions 0 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| dbg_rst | input | 1 | Debug reset, synchronous, active high |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Current register value |
| erase_allow | input | 1 | Mass erase permitted by security settings |
| erase_done | input | 1 | Erase-complete pulse |
| erase_req | output | 1 | Mass erase request |
| sleep_enter | input | 1 | Deep-sleep entry pulse |
| sleep_exit | input | 1 | Deep-sleep recovery pulse |
| sleep_status | output | 1 | Sticky deep-sleep entry flag |
| halt_req | output | 1 | Core halt / wake-to-halt request |
| sys_rst_out | output | 1 | System reset |
| core_rst_out | output | 1 | Core reset |

## Verification
Some properties are checked by assertions on every cycle: a set bit 3 always means system reset; the lockout is sticky and freezes the register; the erase request is blocked while erase is not allowed, and a pending erase bit persists in that case; the recovery hold persists until it is acknowledged; the sticky flag sets after each entry; and the core-park bit carries core reset past the end of system reset. Other behaviours depend on multi-step sequences, and only the bench scenarios show them. These are the sample-on-entry then hold-on-exit order, the release timing after each acknowledge, the selective effect of a debug reset, and bit 0 being cleared by a system reset.

// File: rtl/dbgc_pkg.sv
package dbgc_pkg;
    localparam int CTL_W = 8;

    typedef struct packed {
        logic stat_ack;   // bit 7
        logic lp_ack;     // bit 6
        logic lp_req;     // bit 5
        logic core_park;  // bit 4
        logic sys_rq;     // bit 3
        logic halt;       // bit 2
        logic lock;       // bit 1
        logic erase;      // bit 0
    } ctl_t;

    function automatic logic wr_accept(input logic en, input logic locked);
        return en & ~locked;
    endfunction
endpackage

// File: rtl/dbgc_bits.sv
module dbgc_bits
    import dbgc_pkg::*;
(
    input  logic             clk,
    input  logic             por,
    input  logic             dbg_rst,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    input  logic             erase_done,
    input  logic             erase_allow,
    input  logic             sleep_exit,
    input  logic             sys_rst,
    output ctl_t             q,
    output logic             wr_ok,
    output logic             erase_req
);
    ctl_t wd;
    ctl_t d;

    assign wd        = ctl_t'(wr_data);
    assign wr_ok     = wr_accept(wr_en, q.lock);
    assign erase_req = q.erase & erase_allow;

    always_comb begin
        d = q;
        if (q.erase && erase_allow && erase_done)
            d.erase = 1'b0;
        if (wr_ok) begin
            d.stat_ack  = wd.stat_ack;
            d.lp_ack    = wd.lp_ack;
            d.lp_req    = wd.lp_req;
            d.core_park = wd.core_park;
            d.sys_rq    = wd.sys_rq;
            d.halt      = wd.halt;
            d.lock      = q.lock | wd.lock;
            if (wd.erase)
                d.erase = 1'b1;
        end
        if (sys_rst)
            d.erase = 1'b0;
        if (sleep_exit) begin
            d.lp_req = 1'b0;
            d.lp_ack = 1'b0;
        end
        if (dbg_rst) begin
            d.lock      = 1'b0;
            d.halt      = 1'b0;
            d.sys_rq    = 1'b0;
            d.core_park = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (por)
            q <= '0;
        else
            q <= d;
    end

    // R3: lockout survives everything except debug reset
    a_r3_lock_sticky: assert property (@(posedge clk) disable iff (por)
        (q.lock && !dbg_rst) |=> q.lock);

    // R3: a locked register ignores writes
    a_r3_frozen: assert property (@(posedge clk) disable iff (por)
        (q.lock && wr_en && !dbg_rst && !sleep_exit && !sys_rst && !erase_done)
        |=> $stable(q));

    // R1: completion clears the erase bit unless re-triggered
    a_r1_done_clears: assert property (@(posedge clk) disable iff (por)
        (q.erase && erase_allow && erase_done && !(wr_ok && wd.erase)) |=> !q.erase);
endmodule

// File: rtl/dbgc_sleep.sv
module dbgc_sleep (
    input  logic clk,
    input  logic por,
    input  logic sleep_enter,
    input  logic sleep_exit,
    input  logic lp_req,
    input  logic ack_wr,
    input  logic stat_clr,
    output logic recov_hold,
    output logic sleep_status
);
    logic armed_q;

    always_ff @(posedge clk) begin
        if (por) begin
            armed_q      <= 1'b0;
            recov_hold   <= 1'b0;
            sleep_status <= 1'b0;
        end else begin
            if (sleep_enter)
                sleep_status <= 1'b1;
            else if (stat_clr)
                sleep_status <= 1'b0;

            if (sleep_exit) begin
                recov_hold <= armed_q;
                armed_q    <= 1'b0;
            end else begin
                if (ack_wr)
                    recov_hold <= 1'b0;
                if (sleep_enter)
                    armed_q <= lp_req;
            end
        end
    end

    // R7: the wake hold persists until acknowledged
    a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (por)
        (recov_hold && !ack_wr && !sleep_exit) |=> recov_hold);

    // R9: every entry leaves the sticky flag set
    a_r9_flag_sets: assert property (@(posedge clk) disable iff (por)
        sleep_enter |=> sleep_status);
endmodule

// File: rtl/dbgc_rstseq.sv
module dbgc_rstseq (
    input  logic clk,
    input  logic por,
    input  logic sys_rq,
    input  logic recov_hold,
    input  logic park_bit,
    output logic sys_rst_out,
    output logic core_rst_out
);
    logic parked_q;

    assign sys_rst_out  = sys_rq | recov_hold;
    assign core_rst_out = sys_rst_out | (parked_q & park_bit);

    always_ff @(posedge clk) begin
        if (por)
            parked_q <= 1'b0;
        else
            parked_q <= park_bit & (sys_rst_out | parked_q);
    end
endmodule

// File: rtl/dbg_ctl_reg.sv
module dbg_ctl_reg
    import dbgc_pkg::*;
(
    input  logic             clk,
    input  logic             por,
    input  logic             dbg_rst,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    output logic [CTL_W-1:0] rd_data,
    input  logic             erase_allow,
    input  logic             erase_done,
    output logic             erase_req,
    input  logic             sleep_enter,
    input  logic             sleep_exit,
    output logic             sleep_status,
    output logic             halt_req,
    output logic             sys_rst_out,
    output logic             core_rst_out
);
    ctl_t q;
    logic wr_ok;
    logic recov_hold;

    dbgc_bits u_bits (
        .clk        (clk),
        .por        (por),
        .dbg_rst    (dbg_rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .erase_done (erase_done),
        .erase_allow(erase_allow),
        .sleep_exit (sleep_exit),
        .sys_rst    (sys_rst_out),
        .q          (q),
        .wr_ok      (wr_ok),
        .erase_req  (erase_req)
    );

    dbgc_sleep u_sleep (
        .clk         (clk),
        .por         (por),
        .sleep_enter (sleep_enter),
        .sleep_exit  (sleep_exit),
        .lp_req      (q.lp_req),
        .ack_wr      (wr_ok & wr_data[6]),
        .stat_clr    (wr_ok & wr_data[7]),
        .recov_hold  (recov_hold),
        .sleep_status(sleep_status)
    );

    dbgc_rstseq u_rst (
        .clk         (clk),
        .por         (por),
        .sys_rq      (q.sys_rq),
        .recov_hold  (recov_hold),
        .park_bit    (q.core_park),
        .sys_rst_out (sys_rst_out),
        .core_rst_out(core_rst_out)
    );

    assign rd_data  = q;
    assign halt_req = q.halt;

    // R5: a set reset-request bit always means system reset
    a_r5_sysrst: assert property (@(posedge clk) disable iff (por)
        rd_data[3] |-> sys_rst_out);

    // R2: no erase request without permission
    a_r2_blocked: assert property (@(posedge clk) disable iff (por)
        !erase_allow |-> !erase_req);

    // R2: a blocked erase bit persists until system reset
    a_r2_persists: assert property (@(posedge clk) disable iff (por)
        (rd_data[0] && !erase_allow && !sys_rst_out) |=> rd_data[0]);

    // R6: parking carries core reset past the end of system reset
    a_r6_park: assert property (@(posedge clk) disable iff (por)
        (sys_rst_out && rd_data[4] && !dbg_rst) |=> (core_rst_out || !rd_data[4]));
endmodule

// File: tb/sim_dbg_ctl_reg.sv
`timescale 1ns/1ps
module sim_dbg_ctl_reg;
    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic       dbg_rst = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       erase_allow = 1'b0;
    logic       erase_done = 1'b0;
    logic       sleep_enter = 1'b0;
    logic       sleep_exit = 1'b0;
    logic [7:0] rd_data;
    logic       erase_req, sleep_status, halt_req, sys_rst_out, core_rst_out;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dbg_ctl_reg u0 (
        .clk(clk), .por(por), .dbg_rst(dbg_rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .erase_allow(erase_allow), .erase_done(erase_done),
        .erase_req(erase_req), .sleep_enter(sleep_enter), .sleep_exit(sleep_exit),
        .sleep_status(sleep_status), .halt_req(halt_req), .sys_rst_out(sys_rst_out),
        .core_rst_out(core_rst_out)
    );

    // reference model
    logic [7:0] m_reg = 8'h00;
    logic [7:0] nr;
    bit m_armed = 0, m_wake = 0, m_park = 0, m_stat = 0;
    bit acc, sysr;

    always @(posedge clk) begin
        if (por) begin
            m_reg = 8'h00; m_armed = 0; m_wake = 0; m_park = 0; m_stat = 0;
        end else begin
            sysr = m_reg[3] || m_wake;
            acc  = wr_en && !m_reg[1];
            nr   = m_reg;
            if (m_reg[0] && erase_allow && erase_done) nr[0] = 1'b0;
            if (acc) begin
                nr[7:2] = wr_data[7:2];
                if (wr_data[1]) nr[1] = 1'b1;
                if (wr_data[0]) nr[0] = 1'b1;
            end
            if (sysr) nr[0] = 1'b0;
            if (sleep_exit) nr[6:5] = 2'b00;
            if (dbg_rst) nr[4:1] = 4'b0000;
            m_park = m_reg[4] && (sysr || m_park);
            if (sleep_enter) m_stat = 1;
            else if (acc && wr_data[7]) m_stat = 0;
            if (sleep_exit) begin
                m_wake = m_armed; m_armed = 0;
            end else begin
                if (acc && wr_data[6]) m_wake = 0;
                if (sleep_enter) m_armed = m_reg[5];
            end
            m_reg = nr;
        end
    end

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic compare();
        bit es;
        es = m_reg[3] || m_wake;
        chk(rd_data, m_reg, "R11 rd_data");
        chk({7'd0, sys_rst_out}, {7'd0, es}, "R5 sys_rst_out");
        chk({7'd0, core_rst_out}, {7'd0, es || (m_park && m_reg[4])}, "R6 core_rst_out");
        chk({7'd0, halt_req}, {7'd0, m_reg[2]}, "R4 halt_req");
        chk({7'd0, erase_req}, {7'd0, m_reg[0] && erase_allow}, "R1 erase_req");
        chk({7'd0, sleep_status}, {7'd0, m_stat}, "R9 sleep_status");
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        compare();
    endtask

    task automatic wr(input logic [7:0] v);
        wr_en = 1'b1; wr_data = v;
        step();
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        #400000;
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        idle(3);
        por = 1'b0;
        chk({rd_data, 1'b0}, 9'h0, "R10 reset value");
        chk({3'b0, erase_req, sleep_status, halt_req, sys_rst_out, core_rst_out}, 8'h00, "R10 outputs low");
        step();

        // R4 halt
        wr(8'h04); chk({7'd0, halt_req}, 8'h01, "R4 halt set");
        wr(8'h00); chk({7'd0, halt_req}, 8'h00, "R4 halt clear");

        // R5/R6 park path
        wr(8'h18); chk({7'd0, sys_rst_out}, 8'h01, "R5 reset asserted");
        wr(8'h10); chk({6'd0, sys_rst_out, core_rst_out}, 8'h01, "R6 core parked");
        idle(3);   chk({7'd0, core_rst_out}, 8'h01, "R6 still parked");
        wr(8'h00); chk({7'd0, core_rst_out}, 8'h00, "R6 released after clear");
        // R6 no park
        wr(8'h08); wr(8'h00);
        chk({6'd0, sys_rst_out, core_rst_out}, 8'h00, "R6 released with system");

        // R1 erase
        erase_allow = 1'b1;
        wr(8'h01); chk({7'd0, erase_req}, 8'h01, "R1 erase requested");
        wr(8'h00); chk(rd_data, 8'h01, "R1 write 0 no effect");
        idle(2);
        erase_done = 1'b1; step(); erase_done = 1'b0;
        chk(rd_data, 8'h00, "R1 cleared on done");

        // R2 blocked erase
        erase_allow = 1'b0;
        wr(8'h01); chk({7'd0, erase_req}, 8'h00, "R2 no request");
        erase_done = 1'b1; step(); erase_done = 1'b0;
        idle(3); chk(rd_data, 8'h01, "R2 bit persists");
        wr(8'h08); step(); chk(rd_data[0], 1'b0, "R2 cleared by system reset");
        wr(8'h00);

        // R7/R8/R9 deep sleep with hold
        wr(8'h60);
        sleep_enter = 1'b1; step(); sleep_enter = 1'b0;
        chk({7'd0, sleep_status}, 8'h01, "R9 flag set");
        idle(2);
        sleep_exit = 1'b1; step(); sleep_exit = 1'b0;
        chk(rd_data & 8'h60, 8'h00, "R8 bits cleared on exit");
        chk({7'd0, sys_rst_out}, 8'h01, "R7 hold on exit");
        idle(4); chk({7'd0, sys_rst_out}, 8'h01, "R7 hold persists");
        wr(8'h40); chk({7'd0, sys_rst_out}, 8'h00, "R7 released on ack");
        wr(8'h00); chk(rd_data[6], 1'b0, "R8 ack written back to 0");
        chk({7'd0, sleep_status}, 8'h01, "R9 flag sticky");
        wr(8'h80); chk({7'd0, sleep_status}, 8'h00, "R9 flag cleared");
        chk(rd_data[7], 1'b1, "R9 bit 7 holds written value");
        wr(8'h00);

        // R7 no hold when request was 0
        sleep_enter = 1'b1; step(); sleep_enter = 1'b0;
        wr(8'h20);
        sleep_exit = 1'b1; step(); sleep_exit = 1'b0;
        chk({7'd0, sys_rst_out}, 8'h00, "R7 no hold when sampled 0");
        wr(8'h80); wr(8'h00);

        // R3 lockout, R10 debug reset
        wr(8'h26);
        wr(8'h00); chk(rd_data, 8'h26, "R3 write ignored");
        wr(8'h40); chk(rd_data, 8'h26, "R3 still locked");
        dbg_rst = 1'b1; step(); dbg_rst = 1'b0;
        chk(rd_data, 8'h20, "R10 debug reset clears 1..4 only");
        wr(8'h00); chk(rd_data, 8'h00, "R3 writes accepted after debug reset");

        // R10 power-on reset mid-activity
        wr(8'h1C);
        sleep_enter = 1'b1; step(); sleep_enter = 1'b0;
        por = 1'b1; step(); por = 1'b0;
        chk({rd_data, sleep_status, sys_rst_out, core_rst_out, halt_req}, 12'h000, "R10 por clears all");
        idle(2);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule